// File: doc/BRIEF.md
# Single-Instruction Step Interrupt Generator

This block lets a debug monitor take back control of a processor after exactly one user instruction. It drives an active-low non-maskable interrupt line. The processor always completes the instruction it is running before it services the interrupt. A request raised while an instruction runs therefore returns control to the monitor as soon as that instruction ends.

The block has two ways to generate the request.

- **Fetch-trap mode.** The block watches the processor's opcode-fetch strobe and the fetch address. Every qualifying fetch raises the interrupt. Fetches from inside the monitor's own address window are never stepped, so the monitor cannot trap itself.
- **Timer mode.** The monitor arms a short one-shot countdown just before it returns to user code. The shortest instruction takes two cycles. A count of one or a few cycles therefore fires while the first user instruction is still running.

A single enable bit governs stepping in both modes. It stays set across any number of steps. Clearing it cancels a pending countdown and any pulse in progress.

Software writes two registers through a small write port:

- **Control register** (select 0): enable and mode.
- **Count register** (select 1): the one-shot count.

Top module: `step_nmi_gen`

## Requirements
- R1: While `rst_n` is low and after it is released, `nmi_n` is high, stepping is disabled and no countdown is armed. A reset during a pulse releases `nmi_n` at the next clock edge.
- R2: A write with `wr_sel`=0 sets the control register. `wr_data` bit 0 is the enable (1 = stepping on). `wr_data` bit 1 is the mode (0 = fetch trap, 1 = timer). The enable stays set across any number of steps.
- R3: In fetch-trap mode with stepping enabled, suppose `fetch_strobe` is high at a clock edge with an address outside the monitor window, and it was not high at the previous edge. Then `nmi_n` is low right after that edge.
- R4: Each trigger drives `nmi_n` low for exactly `PULSE_LEN` clocks (default 2, at least 2). A strobe held high over consecutive cycles produces only one pulse.
- R5: Fetches with `MON_LO` <= address <= `MON_HI` never raise the request. Both bounds are inclusive; defaults are 0x1C00 and 0x1FFF.
- R6: In timer mode with stepping enabled, a write with `wr_sel`=1 and nonzero `wr_data`=N arms the countdown. `nmi_n` is high after each of the next N-1 edges and goes low right after the N-th edge following the write edge, for N from 1 to 255.
- R7: An expired countdown fires only once. No further pulse occurs until the count register is written again.
- R8: A count write of zero disarms a pending countdown, so no pulse follows.
- R9: Count writes are ignored while stepping is disabled or in fetch-trap mode. Opcode fetches are ignored in timer mode and while stepping is disabled.
- R10: A control write with bit 0 = 0 cancels a pending countdown and forces `nmi_n` high right after that write's edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_strobe | input | 1 | High during an opcode fetch cycle |
| fetch_addr | input | AW (16) | Address of the current fetch |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = control register, 1 = count register |
| wr_data | input | 8 | Write data |
| nmi_n | output | 1 | Active-low non-maskable interrupt request |

## Verification
Timing is counted from the clock edge that samples the stimulus.

- **Fetch trigger and cancel write:** each shows at `nmi_n` right after that same edge.
- **Armed count of N:** shows right after the N-th later edge, and the pulse then lasts `PULSE_LEN` edges.

The bench applies each vector on a falling edge and compares `nmi_n` at the next falling edge, which is exactly one rising edge later. Every expected level in the table is placed on the row whose edge should produce it. The 255-cycle countdown is checked by a directed loop that requires `nmi_n` to stay high through edge 254 and be low after edge 255.

// File: rtl/step_nmi_pkg.sv
// Shared types for the step interrupt generator.
// Assumes: control register layout is fixed by software (enable bit 0, mode bit 1).
package step_nmi_pkg;
    typedef enum logic {
        MODE_FETCH = 1'b0,
        MODE_TIMER = 1'b1
    } step_mode_e;

    typedef struct packed {
        logic       en;
        step_mode_e mode;
    } step_ctrl_t;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_MODE_BIT = 1;
    localparam int DATA_W        = 8;
endpackage

// File: rtl/step_ctrl_regs.sv
// Control/count register decode.
// Holds enable and mode. Derives the count-load and cancel strobes for the same edge as the write.
// Assumes: writes are single-cycle strobes in the clk domain.
module step_ctrl_regs
    import step_nmi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output step_ctrl_t        ctrl_q,
    output logic              cnt_load,
    output logic [DATA_W-1:0] cnt_value,
    output logic              cancel
);
    step_ctrl_t ctrl_d;

    // Next control value on a select-0 write.
    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en && !wr_sel) begin
            ctrl_d.en   = wr_data[CTRL_EN_BIT];
            ctrl_d.mode = step_mode_e'(wr_data[CTRL_MODE_BIT]);
        end
    end

    // Control register storage.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '{en: 1'b0, mode: MODE_FETCH};
        else        ctrl_q <= ctrl_d;
    end

    // Count writes only take effect while enabled in timer mode.
    always_comb begin
        cnt_load  = wr_en && wr_sel && ctrl_q.en && (ctrl_q.mode == MODE_TIMER);
        cnt_value = wr_data;
        cancel    = wr_en && !wr_sel && !wr_data[CTRL_EN_BIT];
    end
endmodule

// File: rtl/step_fetch_qual.sv
// Opcode-fetch qualification.
// A fetch requests a step only when enabled, in fetch-trap mode, and outside the inclusive monitor window.
// Assumes: MON_HI < MON_LO means no window.
module step_fetch_qual #(
    parameter int             AW     = 16,
    parameter logic [AW-1:0]  MON_LO = 16'h1C00,
    parameter logic [AW-1:0]  MON_HI = 16'h1FFF
) (
    input  logic          fetch_strobe,
    input  logic [AW-1:0] fetch_addr,
    input  logic          step_en,
    input  logic          fetch_mode,
    output logic          fetch_req
);
    logic in_mon;

    generate
        if (MON_HI >= MON_LO) begin : g_window
            // Inclusive window compare.
            always_comb in_mon = (fetch_addr >= MON_LO) && (fetch_addr <= MON_HI);
        end else begin : g_no_window
            // No monitor window configured.
            always_comb in_mon = 1'b0;
        end
    endgenerate

    // Qualified step request.
    always_comb fetch_req = fetch_strobe && !in_mon && step_en && fetch_mode;
endmodule

// File: rtl/step_oneshot.sv
// One-shot countdown.
// Loaded with N, it asserts fire during the cycle before the N-th edge after the load. It never reloads by itself.
// Assumes: load is already gated by enable/timer mode.
module step_oneshot #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] value,
    input  logic          cancel,
    input  logic          active,
    output logic          fire
);
    localparam logic [CW-1:0] ONE = CW'(1);
    logic [CW-1:0] cnt_q;

    // Countdown register: cancel beats load beats decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (cancel)         cnt_q <= '0;
        else if (load)           cnt_q <= value;
        else if (cnt_q != '0)    cnt_q <= cnt_q - ONE;
    end

    // Expiry indication, gated by the current mode.
    always_comb fire = active && (cnt_q == ONE);
endmodule

// File: rtl/step_pulse_gen.sv
// NMI pulse generator.
// Starts a PULSE_LEN-clock low pulse on a rising fetch request or on a timer expiry. Cancel ends it at once.
// Assumes: PULSE_LEN >= 2.
module step_pulse_gen #(
    parameter int PULSE_LEN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fetch_req,
    input  logic fire,
    input  logic cancel,
    output logic nmi_n
);
    localparam int PW = $clog2(PULSE_LEN + 1);
    localparam logic [PW-1:0] LEN = PW'(PULSE_LEN);

    logic          req_d;
    logic          trig;
    logic [PW-1:0] cnt_q, cnt_d;

    generate
        if (PULSE_LEN < 2) begin : g_bad_len
            initial $error("PULSE_LEN must be at least 2");
        end
    endgenerate

    // Trigger on a new fetch request or a timer expiry.
    always_comb trig = (fetch_req && !req_d) || fire;

    // Next pulse counter value.
    always_comb begin
        if (cancel)           cnt_d = '0;
        else if (trig)        cnt_d = LEN;
        else if (cnt_q != '0) cnt_d = cnt_q - PW'(1);
        else                  cnt_d = '0;
    end

    // Registered edge history, counter and output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_d <= 1'b0;
            cnt_q <= '0;
            nmi_n <= 1'b1;
        end else begin
            req_d <= fetch_req;
            cnt_q <= cnt_d;
            nmi_n <= (cnt_d == '0);
        end
    end
endmodule

// File: rtl/step_nmi_gen.sv
// Top: single-instruction step interrupt generator.
// Combines register decode, fetch qualification, one-shot and pulse generation.
// Assumes: all inputs are synchronous to clk.
module step_nmi_gen
    import step_nmi_pkg::*;
#(
    parameter int            AW        = 16,
    parameter logic [AW-1:0] MON_LO    = 16'h1C00,
    parameter logic [AW-1:0] MON_HI    = 16'h1FFF,
    parameter int            PULSE_LEN = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fetch_strobe,
    input  logic [AW-1:0] fetch_addr,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [7:0]    wr_data,
    output logic          nmi_n
);
    step_ctrl_t        ctrl_q;
    logic              cnt_load;
    logic [DATA_W-1:0] cnt_value;
    logic              cancel;
    logic              step_en;
    logic              timer_mode;
    logic              fetch_req;
    logic              timer_fire;

    // Decoded mode flags.
    always_comb begin
        step_en    = ctrl_q.en;
        timer_mode = (ctrl_q.mode == MODE_TIMER);
    end

    step_ctrl_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .ctrl_q(ctrl_q), .cnt_load(cnt_load),
        .cnt_value(cnt_value), .cancel(cancel)
    );

    step_fetch_qual #(.AW(AW), .MON_LO(MON_LO), .MON_HI(MON_HI)) u_qual (
        .fetch_strobe(fetch_strobe), .fetch_addr(fetch_addr),
        .step_en(step_en), .fetch_mode(!timer_mode), .fetch_req(fetch_req)
    );

    step_oneshot #(.CW(DATA_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(cnt_load), .value(cnt_value),
        .cancel(cancel), .active(step_en && timer_mode), .fire(timer_fire)
    );

    step_pulse_gen #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fire(timer_fire),
        .cancel(cancel), .nmi_n(nmi_n)
    );
endmodule

// File: rtl/step_nmi_chk.sv
// Assertion checker for step_nmi_gen, attached by bind.
// Assumes: PULSE_LEN >= 2.
module step_nmi_chk #(
    parameter int            AW     = 16,
    parameter logic [AW-1:0] MON_LO = 16'h1C00,
    parameter logic [AW-1:0] MON_HI = 16'h1FFF
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fetch_strobe,
    input logic [AW-1:0] fetch_addr,
    input logic          wr_en,
    input logic          wr_sel,
    input logic [7:0]    wr_data,
    input logic          nmi_n,
    input logic          step_en,
    input logic          timer_fire
);
    logic in_mon;
    logic cancel_wr;
    always_comb begin
        in_mon    = (fetch_addr >= MON_LO) && (fetch_addr <= MON_HI);
        cancel_wr = wr_en && !wr_sel && !wr_data[0];
    end

    assert_reset_idle_R1: assert property (@(posedge clk) !rst_n |=> nmi_n);

    assert_pulse_min_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(nmi_n) && !cancel_wr) |=> !nmi_n);

    assert_monitor_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_strobe && in_mon && !timer_fire && nmi_n) |=> nmi_n);

    assert_one_shot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_fire && !(wr_en && wr_sel)) |=> !timer_fire);

    assert_zero_disarm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel && wr_data == 8'd0) |=> !timer_fire);

    assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && nmi_n) |=> nmi_n);

    assert_cancel_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cancel_wr |=> nmi_n);
endmodule

bind step_nmi_gen step_nmi_chk #(.AW(AW), .MON_LO(MON_LO), .MON_HI(MON_HI)) u_chk (
    .clk(clk), .rst_n(rst_n), .fetch_strobe(fetch_strobe), .fetch_addr(fetch_addr),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .nmi_n(nmi_n),
    .step_en(step_en), .timer_fire(timer_fire)
);

// File: tb/sim_step_nmi_gen.sv
module sim_step_nmi_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_strobe = 1'b0;
    logic [15:0] fetch_addr = '0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        nmi_n;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    step_nmi_gen u0 (
        .clk(clk), .rst_n(rst_n), .fetch_strobe(fetch_strobe), .fetch_addr(fetch_addr),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .nmi_n(nmi_n)
    );

    // Vector: {wr_en, wr_sel, wr_data[8], strobe, addr[16], exp_nmi, req[4]} = 32 bits
    function automatic logic [31:0] v(input logic we, input logic sel, input logic [7:0] d,
                                      input logic st, input logic [15:0] a,
                                      input logic ex, input logic [3:0] rq);
        return {we, sel, d, st, a, ex, rq};
    endfunction

    localparam int NV = 62;
    localparam logic [31:0] VEC [NV] = '{
        v(1,0,8'h01,0,16'h0000,1,2),  // 0  R2 enable, fetch mode
        v(0,0,8'h00,1,16'h0200,0,3),  // 1  R3 trap
        v(0,0,8'h00,0,16'h0000,0,4),  // 2  R4 second low clock
        v(0,0,8'h00,0,16'h0000,1,4),  // 3  R4 ends
        v(0,0,8'h00,1,16'h0202,0,2),  // 4  R2 enable persists
        v(0,0,8'h00,0,16'h0000,0,4),  // 5
        v(0,0,8'h00,0,16'h0000,1,4),  // 6
        v(0,0,8'h00,1,16'h1C00,1,5),  // 7  R5 low bound
        v(0,0,8'h00,0,16'h0000,1,5),  // 8
        v(0,0,8'h00,1,16'h1FFF,1,5),  // 9  R5 high bound
        v(0,0,8'h00,1,16'h1BFF,0,5),  // 10 R5 just below
        v(0,0,8'h00,0,16'h0000,0,4),  // 11
        v(0,0,8'h00,0,16'h0000,1,4),  // 12
        v(0,0,8'h00,1,16'h2000,0,5),  // 13 R5 just above
        v(0,0,8'h00,0,16'h0000,0,4),  // 14
        v(0,0,8'h00,0,16'h0000,1,4),  // 15
        v(0,0,8'h00,1,16'h0300,0,4),  // 16 R4 held strobe
        v(0,0,8'h00,1,16'h0301,0,4),  // 17
        v(0,0,8'h00,1,16'h0302,1,4),  // 18 R4 no second pulse
        v(0,0,8'h00,0,16'h0000,1,4),  // 19
        v(1,0,8'h03,0,16'h0000,1,2),  // 20 R2 timer mode
        v(0,0,8'h00,1,16'h0400,1,9),  // 21 R9 fetch ignored in timer mode
        v(1,1,8'd3,0,16'h0000,1,6),   // 22 R6 arm 3
        v(0,0,8'h00,0,16'h0000,1,6),  // 23
        v(0,0,8'h00,0,16'h0000,1,6),  // 24
        v(0,0,8'h00,0,16'h0000,0,6),  // 25 R6 fires on 3rd edge
        v(0,0,8'h00,0,16'h0000,0,4),  // 26
        v(0,0,8'h00,0,16'h0000,1,4),  // 27
        v(0,0,8'h00,0,16'h0000,1,7),  // 28 R7 once
        v(0,0,8'h00,0,16'h0000,1,7),  // 29 R7
        v(1,1,8'd1,0,16'h0000,1,6),   // 30 R6 arm 1
        v(0,0,8'h00,0,16'h0000,0,6),  // 31 R6
        v(0,0,8'h00,0,16'h0000,0,4),  // 32
        v(0,0,8'h00,0,16'h0000,1,4),  // 33
        v(1,1,8'd5,0,16'h0000,1,8),   // 34 R8 arm 5
        v(1,1,8'd0,0,16'h0000,1,8),   // 35 R8 disarm
        v(0,0,8'h00,0,16'h0000,1,8),  // 36
        v(0,0,8'h00,0,16'h0000,1,8),  // 37
        v(0,0,8'h00,0,16'h0000,1,8),  // 38
        v(0,0,8'h00,0,16'h0000,1,8),  // 39 R8 would have fired
        v(0,0,8'h00,0,16'h0000,1,8),  // 40
        v(0,0,8'h00,0,16'h0000,1,8),  // 41
        v(1,1,8'd4,0,16'h0000,1,10),  // 42 R10 arm 4
        v(0,0,8'h00,0,16'h0000,1,10), // 43
        v(0,0,8'h00,0,16'h0000,1,10), // 44
        v(1,0,8'h02,0,16'h0000,1,10), // 45 R10 disable
        v(0,0,8'h00,0,16'h0000,1,10), // 46 R10 would have fired
        v(0,0,8'h00,0,16'h0000,1,10), // 47
        v(0,0,8'h00,0,16'h0000,1,10), // 48
        v(1,0,8'h03,0,16'h0000,1,10), // 49 re-enable, no stale count
        v(0,0,8'h00,0,16'h0000,1,10), // 50
        v(0,0,8'h00,0,16'h0000,1,10), // 51
        v(0,0,8'h00,0,16'h0000,1,10), // 52
        v(1,0,8'h02,0,16'h0000,1,9),  // 53 R9 disabled
        v(1,1,8'd2,0,16'h0000,1,9),   // 54 R9 count ignored
        v(0,0,8'h00,0,16'h0000,1,9),  // 55
        v(0,0,8'h00,0,16'h0000,1,9),  // 56
        v(0,0,8'h00,0,16'h0000,1,9),  // 57
        v(1,0,8'h01,0,16'h0000,1,2),  // 58 fetch mode on
        v(0,0,8'h00,1,16'h0500,0,3),  // 59 R3
        v(1,0,8'h00,0,16'h0000,1,10), // 60 R10 release mid pulse
        v(0,0,8'h00,1,16'h0600,1,9)   // 61 R9 fetch ignored when disabled
    };

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: nmi_n=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle();
        wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
        fetch_strobe = 1'b0; fetch_addr = '0;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: done=0 expected 1");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic stayed_high;
        repeat (3) @(negedge clk);
        check("R1", nmi_n, 1'b1);            // in reset
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", nmi_n, 1'b1);            // after release
        fetch_strobe = 1'b1; fetch_addr = 16'h0200;  // R1: stepping disabled after reset
        @(negedge clk);
        check("R1", nmi_n, 1'b1);
        idle();

        for (int i = 0; i < NV; i++) begin
            {wr_en, wr_sel, wr_data, fetch_strobe, fetch_addr} = VEC[i][31:5];
            @(negedge clk);
            check($sformatf("R%0d row %0d", VEC[i][3:0], i), nmi_n, VEC[i][4]);
        end
        idle();

        // R6 boundary: full-range count 255
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'h03;
        @(negedge clk);
        wr_sel = 1'b1; wr_data = 8'd255;
        @(negedge clk);              // after write edge E0
        idle();
        stayed_high = nmi_n;
        for (int k = 1; k <= 254; k++) begin
            @(negedge clk);
            stayed_high &= nmi_n;
        end
        check("R6 count 255 holds", stayed_high, 1'b1);
        @(negedge clk);
        check("R6 count 255 fires", nmi_n, 1'b0);

        // R1: reset during a pulse
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'h01;
        @(negedge clk);
        idle();
        @(negedge clk);
        fetch_strobe = 1'b1; fetch_addr = 16'h0700;
        @(negedge clk);
        check("R3 before reset", nmi_n, 1'b0);
        idle();
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid pulse", nmi_n, 1'b1);
        rst_n = 1'b1;
        fetch_strobe = 1'b1; fetch_addr = 16'h0800;
        @(negedge clk);
        check("R1 enable cleared", nmi_n, 1'b1);
        idle();

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule